// File: doc/BRIEF.md
# TLB Invalidation Engine Array with Hardware Semaphores

This block sits in a GPU memory hub and gives software a set of identical invalidation engines. Each engine appears on a simple register bus as three words: a semaphore, a request and an acknowledge mask. Software takes an engine's semaphore by reading it. It writes a request that names a VMID and polls the acknowledge mask until that VMID's bit is set. It then frees the semaphore by writing zero. The block also holds a 64-bit page-table base for each VMID, split into a low and a high word.

When an engine starts an invalidation, it sends a one-cycle pulse toward the TLB. The pulse carries the VMID and the page-table base captured for that VMID. The engine then completes after a fixed latency. Requests that arrive while an engine is busy are kept and served one after another. A parameter selects the hub flavour. The multimedia hub arbitrates its semaphores. The graphics hub has no semaphore, so every semaphore read there reports success.

Top module: `tlbi_engine_array`

## Requirements
- R1: After reset every acknowledge mask reads 0, every semaphore is free, every page-table base word reads 0 and no invalidate pulse is raised.
- R2: A read of an engine's semaphore word (offset +0) returns 1 in bit 0 when the semaphore is free or already owned by the reading requester (`bus_src`), and a read of a free semaphore makes that requester its owner.
- R3: While a semaphore is owned, a read by any other requester returns 0 and leaves the owner unchanged.
- R4: A write of value 0 to the semaphore word by its owner frees it; a write of 0 by another requester, or a nonzero write by anyone, has no effect.
- R5: The low and high page-table base words of VMID v sit at CTX_BASE + v*CTX_STRIDE + 0 and + 1, and read back what was written.
- R6: Engine e occupies ENG_BASE + e*ENG_STRIDE with the semaphore at +0, the request at +1 (VMID in bits [VMID_W-1:0]) and the acknowledge mask at +2. Reads of the request word and of unmapped addresses return 0.
- R7: A request for VMID v clears bit v of that engine's acknowledge mask in the cycle after the write. On an idle engine the bit becomes 1 ACK_LAT cycles after the capturing edge, and acknowledge bits stay set until the next request for that VMID.
- R8: Each invalidation start raises that engine's `inv_pulse` bit for exactly one cycle, in the cycle after the start edge. The pulse carries the VMID on `inv_vmid` and the base {high, low} of that VMID on `inv_base`.
- R9: Requests written while an engine is busy are kept. The next one starts one cycle after the current one completes, and the lowest-numbered pending VMID is taken first.
- R10: Engines run independently of one another. With the default of 18 engines, index 17 (kept for the kernel's own aperture flushes) is present and works like any other engine.
- R11: With SEM_EN = 0 (graphics hub), every semaphore read returns 1 for every requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; the semaphore side effect takes place at the clock edge |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_src | input | SRC_W | Identifier of the requester performing the access |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| inv_pulse | output | NUM_ENG | One-cycle invalidate pulse, one bit per engine |
| inv_vmid | output | NUM_ENG*VMID_W | VMID of each engine's current invalidation |
| inv_base | output | NUM_ENG*64 | Page-table base of each engine's current invalidation |

## Verification
A request captured on edge k shows its pulse in the cycle after k. On an idle engine its acknowledge bit is readable ACK_LAT edges later. A queued request starts one edge after the previous completion, so its pulse comes ACK_LAT+1 cycles after the earlier pulse. The bench counts rising edges and computes every expected pulse cycle and acknowledge sample cycle from that counter. It drives and samples at falling edges and reads the acknowledge mask exactly one cycle before and at the due cycle. The scoreboard checks each pulse against the cycle number stored with its expected item, and it flags an item whose cycle passes without a pulse.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned BASE_W = 64;

  typedef enum logic [1:0] {
    REG_SEM  = 2'd0,
    REG_REQ  = 2'd1,
    REG_ACK  = 2'd2,
    REG_NONE = 2'd3
  } eng_reg_e;

endpackage

// File: rtl/tlbi_decode.sv
module tlbi_decode
  import tlbi_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned NUM_ENG    = 18,
  parameter int unsigned ENG_BASE   = 0,
  parameter int unsigned ENG_STRIDE = 4,
  parameter int unsigned NUM_VMID   = 16,
  parameter int unsigned CTX_BASE   = 256,
  parameter int unsigned CTX_STRIDE = 2,
  localparam int unsigned ENG_W     = $clog2(NUM_ENG),
  localparam int unsigned VMID_W    = $clog2(NUM_VMID)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              eng_hit,
  output logic [ENG_W-1:0]  eng_idx,
  output eng_reg_e          eng_reg,
  output logic              ctx_hit,
  output logic [VMID_W-1:0] ctx_idx,
  output logic              ctx_hi
);

  localparam int unsigned ENG_SPAN = NUM_ENG * ENG_STRIDE;
  localparam int unsigned CTX_SPAN = NUM_VMID * CTX_STRIDE;

  int unsigned a_full;
  int unsigned eng_off;
  int unsigned ctx_off;

  always_comb begin
    a_full  = 32'(addr);
    eng_off = a_full - ENG_BASE;
    ctx_off = a_full - CTX_BASE;
    eng_hit = 1'b0;
    eng_idx = '0;
    eng_reg = REG_NONE;
    ctx_hit = 1'b0;
    ctx_idx = '0;
    ctx_hi  = 1'b0;
    if (eng_off < ENG_SPAN) begin
      eng_idx = ENG_W'(eng_off / ENG_STRIDE);
      case (eng_off % ENG_STRIDE)
        0:       begin eng_reg = REG_SEM; eng_hit = 1'b1; end
        1:       begin eng_reg = REG_REQ; eng_hit = 1'b1; end
        2:       begin eng_reg = REG_ACK; eng_hit = 1'b1; end
        default: eng_reg = REG_NONE;
      endcase
    end
    if (!eng_hit && (ctx_off < CTX_SPAN) && ((ctx_off % CTX_STRIDE) < 2)) begin
      ctx_hit = 1'b1;
      ctx_idx = VMID_W'(ctx_off / CTX_STRIDE);
      ctx_hi  = ((ctx_off % CTX_STRIDE) == 1);
    end
  end

endmodule

// File: rtl/tlbi_sem.sv
module tlbi_sem #(
  parameter int unsigned SRC_W  = 2,
  parameter bit          SEM_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic             wr_zero,
  input  logic [SRC_W-1:0] src,
  output logic             grant
);

  generate
    if (SEM_EN) begin : g_sem
      logic             held_q, held_d;
      logic [SRC_W-1:0] own_q, own_d;
      logic             own_en;

      assign grant = !held_q || (own_q == src);

      always_comb begin
        held_d = held_q;
        own_d  = own_q;
        own_en = 1'b0;
        if (rd_hit && !held_q) begin
          held_d = 1'b1;
          own_d  = src;
          own_en = 1'b1;
        end else if (wr_hit && wr_zero && held_q && (own_q == src)) begin
          held_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held_q <= 1'b0;
          own_q  <= '0;
        end else begin
          held_q <= held_d;
          if (own_en) own_q <= own_d;
        end
      end

      AST_SEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !(wr_hit && wr_zero)) |=> (held_q && $stable(own_q))); // R3

      AST_SEM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && wr_hit && wr_zero && (own_q == src)) |=> !held_q); // R4

      AST_SEM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_q && rd_hit) |=> (held_q && (own_q == $past(src)))); // R2
    end else begin : g_nosem
      logic unused_in;
      assign unused_in = ^{clk, rst_n, rd_hit, wr_hit, wr_zero, src};
      assign grant = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/tlbi_seq.sv
module tlbi_seq #(
  parameter int unsigned NUM_VMID = 16,
  parameter int unsigned ACK_LAT  = 4,
  localparam int unsigned VMID_W  = $clog2(NUM_VMID),
  localparam int unsigned CNT_W   = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic [VMID_W-1:0]   req_vmid,
  output logic [VMID_W-1:0]   sel_vmid,
  input  logic [63:0]         sel_base,
  output logic [NUM_VMID-1:0] ack,
  output logic                inv_pulse,
  output logic [VMID_W-1:0]   inv_vmid,
  output logic [63:0]         inv_base
);

  logic [NUM_VMID-1:0] pend_q, pend_d, ack_q, ack_d;
  logic [NUM_VMID-1:0] new_mask, cand, done_mask;
  logic                busy_q, busy_d, pulse_q, pulse_d;
  logic [VMID_W-1:0]   cur_q, cur_d, pick;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [63:0]         base_q, base_d;
  logic                pick_vld, start, done, cnt_en, cur_en;

  always_comb begin
    new_mask = req_wr ? (NUM_VMID'(1) << req_vmid) : '0;
    cand     = pend_q | new_mask;
    pick_vld = 1'b0;
    pick     = '0;
    for (int i = NUM_VMID - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_vld = 1'b1;
        pick     = VMID_W'(i);
      end
    end
    start     = !busy_q && pick_vld;
    done      = busy_q && (cnt_q == '0);
    done_mask = done ? (NUM_VMID'(1) << cur_q) : '0;

    pend_d = cand;
    if (start) pend_d[pick] = 1'b0;
    busy_d = start ? 1'b1 : (done ? 1'b0 : busy_q);
    cnt_en = start || (busy_q && (cnt_q != '0));
    cnt_d  = start ? CNT_W'(ACK_LAT - 1) : (cnt_q - CNT_W'(1));
    cur_en = start;
    cur_d  = pick;
    base_d = sel_base;
    ack_d  = (ack_q | (done_mask & ~cand)) & ~new_mask;
    pulse_d = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      ack_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
      cur_q   <= '0;
      base_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      ack_q   <= ack_d;
      busy_q  <= busy_d;
      pulse_q <= pulse_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (cur_en) begin
        cur_q  <= cur_d;
        base_q <= base_d;
      end
    end
  end

  assign sel_vmid  = pick;
  assign ack       = ack_q;
  assign inv_pulse = pulse_q;
  assign inv_vmid  = cur_q;
  assign inv_base  = base_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> !inv_pulse); // R8

  AST_REQ_CLEARS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> !ack[$past(req_vmid)]); // R7

  AST_ACK_ON_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~$past(ack)) != '0) |-> $past(busy_q)); // R7

  AST_PULSE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |-> busy_q); // R8

endmodule

// File: rtl/tlbi_ctx.sv
module tlbi_ctx #(
  parameter int unsigned NUM_VMID = 16,
  parameter int unsigned NUM_ENG  = 18,
  localparam int unsigned VMID_W  = $clog2(NUM_VMID)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [VMID_W-1:0]         wr_idx,
  input  logic                      wr_hi,
  input  logic [31:0]               wdata,
  input  logic [VMID_W-1:0]         rd_idx,
  input  logic                      rd_hi,
  output logic [31:0]               rd_data,
  input  logic [NUM_ENG*VMID_W-1:0] sel_vmid,
  output logic [NUM_ENG*64-1:0]     sel_base
);

  logic [31:0] lo_q [NUM_VMID];
  logic [31:0] hi_q [NUM_VMID];
  logic        lo_en, hi_en;

  assign lo_en = wr_en && !wr_hi;
  assign hi_en = wr_en && wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VMID; v++) begin
        lo_q[v] <= '0;
        hi_q[v] <= '0;
      end
    end else begin
      if (lo_en) lo_q[wr_idx] <= wdata;
      if (hi_en) hi_q[wr_idx] <= wdata;
    end
  end

  assign rd_data = rd_hi ? hi_q[rd_idx] : lo_q[rd_idx];

  generate
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_sel
      assign sel_base[e*64 +: 64] = {hi_q[sel_vmid[e*VMID_W +: VMID_W]],
                                     lo_q[sel_vmid[e*VMID_W +: VMID_W]]};
    end
  endgenerate

endmodule

// File: rtl/tlbi_engine_array.sv
module tlbi_engine_array
  import tlbi_pkg::*;
#(
  parameter int unsigned NUM_ENG    = 18,
  parameter int unsigned NUM_VMID   = 16,
  parameter int unsigned SRC_W      = 2,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned ENG_BASE   = 0,
  parameter int unsigned ENG_STRIDE = 4,
  parameter int unsigned CTX_BASE   = 256,
  parameter int unsigned CTX_STRIDE = 2,
  parameter int unsigned ACK_LAT    = 4,
  parameter bit          SEM_EN     = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_wr,
  input  logic                                  bus_rd,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [31:0]                           bus_wdata,
  input  logic [SRC_W-1:0]                      bus_src,
  output logic [31:0]                           bus_rdata,
  output logic [NUM_ENG-1:0]                    inv_pulse,
  output logic [NUM_ENG*$clog2(NUM_VMID)-1:0]   inv_vmid,
  output logic [NUM_ENG*64-1:0]                 inv_base
);

  localparam int unsigned VMID_W = $clog2(NUM_VMID);
  localparam int unsigned ENG_W  = $clog2(NUM_ENG);

  logic rst_s1_q, rst_s2_q, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign srst_n = rst_s2_q;

  logic              eng_hit, ctx_hit, ctx_hi;
  logic [ENG_W-1:0]  eng_idx;
  eng_reg_e          eng_reg;
  logic [VMID_W-1:0] ctx_idx;
  logic [31:0]       ctx_rdata;
  logic              wr_zero;

  tlbi_decode #(
    .ADDR_W(ADDR_W), .NUM_ENG(NUM_ENG), .ENG_BASE(ENG_BASE),
    .ENG_STRIDE(ENG_STRIDE), .NUM_VMID(NUM_VMID), .CTX_BASE(CTX_BASE),
    .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr(bus_addr), .eng_hit(eng_hit), .eng_idx(eng_idx), .eng_reg(eng_reg),
    .ctx_hit(ctx_hit), .ctx_idx(ctx_idx), .ctx_hi(ctx_hi)
  );

  assign wr_zero = (bus_wdata == '0);

  logic [NUM_ENG-1:0]        sem_grant;
  logic [NUM_VMID-1:0]       ack_arr [NUM_ENG];
  logic [NUM_ENG*VMID_W-1:0] sel_vmid;
  logic [NUM_ENG*64-1:0]     sel_base;

  generate
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      logic sel_eng, sem_rd, sem_wr, req_wr;
      assign sel_eng = eng_hit && (eng_idx == ENG_W'(e));
      assign sem_rd  = bus_rd && sel_eng && (eng_reg == REG_SEM);
      assign sem_wr  = bus_wr && sel_eng && (eng_reg == REG_SEM);
      assign req_wr  = bus_wr && sel_eng && (eng_reg == REG_REQ);

      tlbi_sem #(.SRC_W(SRC_W), .SEM_EN(SEM_EN)) u_sem (
        .clk(clk), .rst_n(srst_n), .rd_hit(sem_rd), .wr_hit(sem_wr),
        .wr_zero(wr_zero), .src(bus_src), .grant(sem_grant[e])
      );

      tlbi_seq #(.NUM_VMID(NUM_VMID), .ACK_LAT(ACK_LAT)) u_seq (
        .clk(clk), .rst_n(srst_n), .req_wr(req_wr),
        .req_vmid(bus_wdata[VMID_W-1:0]),
        .sel_vmid(sel_vmid[e*VMID_W +: VMID_W]),
        .sel_base(sel_base[e*64 +: 64]),
        .ack(ack_arr[e]), .inv_pulse(inv_pulse[e]),
        .inv_vmid(inv_vmid[e*VMID_W +: VMID_W]),
        .inv_base(inv_base[e*64 +: 64])
      );
    end
  endgenerate

  tlbi_ctx #(.NUM_VMID(NUM_VMID), .NUM_ENG(NUM_ENG)) u_ctx (
    .clk(clk), .rst_n(srst_n), .wr_en(bus_wr && ctx_hit), .wr_idx(ctx_idx),
    .wr_hi(ctx_hi), .wdata(bus_wdata), .rd_idx(ctx_idx), .rd_hi(ctx_hi),
    .rd_data(ctx_rdata), .sel_vmid(sel_vmid), .sel_base(sel_base)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (eng_hit) begin
        case (eng_reg)
          REG_SEM: bus_rdata = {31'd0, sem_grant[eng_idx]};
          REG_ACK: bus_rdata = 32'(ack_arr[eng_idx]);
          default: bus_rdata = '0;
        endcase
      end else if (ctx_hit) begin
        bus_rdata = ctx_rdata;
      end
    end
  end

  AST_SEM_READ_BIT0_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && eng_hit && (eng_reg == REG_SEM)) |-> (bus_rdata[31:1] == '0)); // R2

  AST_REQ_READS_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && eng_hit && (eng_reg == REG_REQ)) |-> (bus_rdata == '0)); // R6

endmodule

// File: tb/tb_tlbi_engine_array.sv
module tb_tlbi_engine_array;

  localparam int CLK_PERIOD = 10;
  localparam int NE  = 18;
  localparam int NV  = 16;
  localparam int VW  = 4;
  localparam int AW  = 10;
  localparam int SW  = 2;
  localparam int LAT = 4;
  localparam int CTXB = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [SW-1:0] bus_src = '0;
  logic [31:0]   bus_rdata, rdata_g;
  logic [NE-1:0] inv_pulse;
  logic [NE*VW-1:0] inv_vmid;
  logic [NE*64-1:0] inv_base;
  logic [1:0]    inv_pulse_g;
  logic [2*VW-1:0] inv_vmid_g;
  logic [127:0]  inv_base_g;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbi_engine_array dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src(bus_src),
    .bus_rdata(bus_rdata), .inv_pulse(inv_pulse), .inv_vmid(inv_vmid),
    .inv_base(inv_base)
  );

  tlbi_engine_array #(.NUM_ENG(2), .SEM_EN(1'b0)) dut_gfx (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src(bus_src),
    .bus_rdata(rdata_g), .inv_pulse(inv_pulse_g), .inv_vmid(inv_vmid_g),
    .inv_base(inv_base_g)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic mon_en = 1'b0;
  logic [31:0] last_g;

  typedef struct {
    int          eng;
    int          vmid;
    int          due;
    logic [63:0] base;
  } exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor: each pulse must match the oldest expected item
  always @(negedge clk) begin
    if (mon_en) begin
      for (int e = 0; e < NE; e++) begin
        if (inv_pulse[e]) begin
          if (exp_q.size() == 0) begin
            check("R8 unexpected pulse engine", 64'(e), 64'hFFFF);
          end else begin
            exp_t x;
            x = exp_q.pop_front();
            check("R8 pulse engine", 64'(e), 64'(x.eng));
            check("R9 pulse vmid", 64'(inv_vmid[e*VW +: VW]), 64'(x.vmid));
            check("R7 pulse cycle", 64'(cyc), 64'(x.due));
            check("R8 pulse base", inv_base[e*64 +: 64], x.base);
          end
        end
      end
      if (exp_q.size() != 0 && exp_q[0].due < cyc) begin
        check("R8 missing pulse due cycle", 64'(cyc), 64'(exp_q[0].due));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input int src, input int addr, input logic [31:0] d);
    bus_src = SW'(src); bus_addr = AW'(addr); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int src, input int addr, output logic [31:0] d);
    bus_src = SW'(src); bus_addr = AW'(addr); bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    last_g = rdata_g;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int ea(input int e, input int r);
    return e * 4 + r;
  endfunction

  function automatic int ca(input int v, input int h);
    return CTXB + v * 2 + h;
  endfunction

  function automatic logic [63:0] mkbase(input int v);
    return {32'hB000_0000 + 32'(v), 32'hA000_1000 + 32'(v * 16)};
  endfunction

  task automatic set_ctx(input int v);
    logic [63:0] b;
    b = mkbase(v);
    bus_write(0, ca(v, 0), b[31:0]);
    bus_write(0, ca(v, 1), b[63:32]);
  endtask

  // Driver: pushes the expected pulse, then issues the request
  task automatic send_req(input int e, input int v, input int due);
    exp_t x;
    x.eng = e; x.vmid = v; x.due = due; x.base = mkbase(v);
    exp_q.push_back(x);
    bus_write(1, ea(e, 1), 32'(v));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R1 reset state
    check("R1 no pulse after reset", 64'(inv_pulse), 64'h0);
    bus_read(0, ea(2, 2), d);  check("R1 ack mask", 64'(d), 64'h0);
    bus_read(0, ca(5, 1), d);  check("R1 base word", 64'(d), 64'h0);
    bus_read(0, ea(0, 0), d);  check("R1 semaphore free", 64'(d), 64'h1);
    bus_write(0, ea(0, 0), 32'h0);

    // R2 R3 R4 semaphore arbitration on engine 3
    bus_read(1, ea(3, 0), d);  check("R2 first read grants", 64'(d), 64'h1);
    bus_read(2, ea(3, 0), d);  check("R3 other requester refused", 64'(d), 64'h0);
    bus_read(1, ea(3, 0), d);  check("R2 owner reread", 64'(d), 64'h1);
    bus_write(2, ea(3, 0), 32'h0);
    bus_read(2, ea(3, 0), d);  check("R4 non-owner release ignored", 64'(d), 64'h0);
    bus_write(1, ea(3, 0), 32'h1);
    bus_read(2, ea(3, 0), d);  check("R4 nonzero write ignored", 64'(d), 64'h0);
    bus_write(1, ea(3, 0), 32'h0);
    bus_read(2, ea(3, 0), d);  check("R4 owner release then grant", 64'(d), 64'h1);
    bus_read(1, ea(3, 0), d);  check("R3 previous owner now refused", 64'(d), 64'h0);
    bus_write(2, ea(3, 0), 32'h0);

    // R5 R6 register map
    for (int v = 0; v < NV; v++) set_ctx(v);
    bus_read(0, ca(7, 0), d);  check("R5 low word", 64'(d), 64'(mkbase(7) & 64'hFFFF_FFFF));
    bus_read(0, ca(7, 1), d);  check("R5 high word", 64'(d), 64'(mkbase(7) >> 32));
    bus_read(0, ea(2, 1), d);  check("R6 request word reads 0", 64'(d), 64'h0);
    bus_read(0, 'h3F0, d);     check("R6 unmapped reads 0", 64'(d), 64'h0);
    bus_read(0, ea(2, 3), d);  check("R6 stride gap reads 0", 64'(d), 64'h0);

    // R7 R8 latency on idle engine 2, VMID 5
    c0 = cyc;
    send_req(2, 5, c0 + 1);
    wait_until(c0 + 4);
    bus_read(0, ea(2, 2), d);  check("R7 ack not yet set", 64'(d), 64'h0);
    bus_read(0, ea(2, 2), d);  check("R7 ack set after latency", 64'(d), 64'h20);
    // second request for VMID 5 clears the bit next cycle
    c0 = cyc;
    send_req(2, 5, c0 + 1);
    bus_read(0, ea(2, 2), d);  check("R7 request clears ack", 64'(d), 64'h0);
    wait_until(c0 + 4);
    bus_read(0, ea(2, 2), d);  check("R7 cleared until latency", 64'(d), 64'h0);
    bus_read(0, ea(2, 2), d);  check("R7 ack set again", 64'(d), 64'h20);
    repeat (3) @(negedge clk);
    bus_read(0, ea(2, 2), d);  check("R7 ack is sticky", 64'(d), 64'h20);

    // R9 queued requests and lowest-VMID-first order on engine 4
    c0 = cyc;
    send_req(4, 9, c0 + 1);
    begin
      exp_t x;
      x.eng = 4; x.vmid = 3; x.due = c0 + 6;  x.base = mkbase(3);
      bus_write(1, ea(4, 1), 32'd7);
      bus_write(1, ea(4, 1), 32'd3);
      exp_q.push_back(x);
      x.vmid = 7; x.due = c0 + 11; x.base = mkbase(7);
      exp_q.push_back(x);
    end
    wait_until(c0 + 9);
    bus_read(0, ea(4, 2), d);  check("R9 only first done", 64'(d), 64'h0200);
    bus_read(0, ea(4, 2), d);  check("R9 lowest pending second", 64'(d), 64'h0208);
    bus_read(0, ea(2, 2), d);  check("R10 other engine untouched", 64'(d), 64'h20);
    wait_until(c0 + 15);
    bus_read(0, ea(4, 2), d);  check("R9 queued request not dropped", 64'(d), 64'h0288);

    // R10 engine 17 with the system context
    c0 = cyc;
    send_req(17, 0, c0 + 1);
    wait_until(c0 + 5);
    bus_read(0, ea(17, 2), d); check("R10 engine 17 ack", 64'(d), 64'h1);

    // R11 graphics hub flavour has no semaphore
    bus_read(2, ea(1, 0), d);  check("R11 gfx grant first", 64'(last_g), 64'h1);
    check("R2 main hub grant", 64'(d), 64'h1);
    bus_read(3, ea(1, 0), d);  check("R11 gfx grant second requester", 64'(last_g), 64'h1);
    check("R3 main hub refuses second", 64'(d), 64'h0);
    bus_write(2, ea(1, 0), 32'h0);

    repeat (4) @(negedge clk);
    check("R8 all expected pulses seen", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule